// File: doc/BRIEF.md
# Dead-Zone Phase-Frequency Detector with Lock Shutdown

This block is the coarse frequency-acquisition detector of a fractional-N synthesizer, built as synchronous logic in a fast sampling clock. Reference rising edges, reference falling edges and divided-oscillator rising edges arrive as one-cycle strobes. A tri-state core holds an "up" or "down" error flag from the leading edge until the lagging edge, and clears both flags when both would be set. The flags are not sent directly to the charge pump. They are retimed only at reference falling edges, which occur half a reference period after the rising edges. An error pulse that is already over by then never reaches the outputs, so phase errors inside plus or minus half a reference period cause no correction.

Outside that dead zone, the detector drives the frequency-acquisition charge pump hard. Inside it, the fine sub-sampling loop takes control. A lock counter counts consecutive reference periods with no retimed error. When it reaches a programmable count, the block drops `enable`, forces its outputs low and ignores all strobes until a restart pulse re-arms it.

Top module: `dz_freq_detector`

## Requirements
- R1: After reset, `up_q` and `dn_q` are 0, `enable` is 1 and the lock counter is empty.
- R2: A reference strobe with no pending down error sets the internal up flag, and a divider strobe with no pending up error sets the internal down flag. A strobe that would make both flags high clears both flags instead.
- R3: `up_q` and `dn_q` change only in the cycle after a `ref_fall` strobe, or on a clear. At that point they take the core flag levels held just before the strobe cycle.
- R4: An error flag that has cleared before the `ref_fall` strobe cycle never appears on the outputs. With a 16-cycle reference period whose fall is at cycle 8, an up error from cycle 0 that ends at cycle 7 is suppressed, while one that ends at cycle 8 or later is passed.
- R5: When the divider edge leads the reference edge, the error appears on `dn_q` and not on `up_q`.
- R6: If `ref_rise` and `div_rise` arrive in the same cycle with both flags low, neither flag is raised.
- R7: After LOCK_COUNT consecutive `ref_fall` strobes that each find both core flags low, `enable` is 0 from the cycle after the last such strobe. While `enable` is 0, `up_q` and `dn_q` stay 0 and all strobes are ignored.
- R8: A `ref_fall` strobe that finds a core flag high, while unlocked, empties the lock counter.
- R9: A `restart` pulse empties the lock counter, clears the lock, the core flags and the outputs, and `enable` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_rise | input | 1 | One-cycle strobe at each reference rising edge |
| ref_fall | input | 1 | One-cycle strobe at each reference falling edge |
| div_rise | input | 1 | One-cycle strobe at each divided-oscillator rising edge |
| restart | input | 1 | Clears lock state and re-arms the detector |
| up_q | output | 1 | Retimed speed-up request to the charge pump |
| dn_q | output | 1 | Retimed slow-down request to the charge pump |
| enable | output | 1 | High while the acquisition loop is active |

## Verification
The embedded assertions check three things on every cycle: the two core flags are never high together, the retimed outputs hold between fall strobes and copy the pre-strobe flag level when a strobe arrives, and restart or a found error empties the counter. Silence of the outputs while locked is also checked every cycle. The placement of the dead-zone edge, the direction of a leading divider edge, the exact number of clean periods needed to lock, and the re-arming after restart or after an error can only be shown by the bench. Its scenarios drive whole reference periods with chosen edge positions and compare against a behavioural model on every clock.

// File: rtl/dzpfd_pkg.sv
package dzpfd_pkg;

    // Pair of error flags, up in bit 1, down in bit 0.
    typedef struct packed {
        logic up;
        logic dn;
    } err_pair_t;

    localparam int unsigned LANES = 2;

endpackage

// File: rtl/dzpfd_tristate.sv
module dzpfd_tristate
    import dzpfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ref_rise,
    input  logic      div_rise,
    input  logic      clear,
    output err_pair_t err_o
);

    err_pair_t flags_d, flags_q;
    logic      want_up, want_dn;

    always_comb begin
        flags_d = flags_q;
        want_up = flags_q.up | ref_rise;
        want_dn = flags_q.dn | div_rise;
        if (clear) begin
            flags_d = '0;
        end else if (want_up && want_dn) begin
            // Mutual reset: the lagging edge (or a coincident pair) clears both.
            flags_d = '0;
        end else begin
            flags_d.up = want_up;
            flags_d.dn = want_dn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign err_o = flags_q;

    // R2: both flags never high together
    a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_o.up && err_o.dn));

    // R2: a lone reference edge with nothing pending raises up
    a_r2_ref_sets_up: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_rise && !div_rise && !err_o.dn && !clear) |=> err_o.up);

    // R6: coincident strobes from idle raise nothing
    a_r6_coincident_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_rise && div_rise && !err_o.up && !err_o.dn) |=> (!err_o.up && !err_o.dn));

endmodule

// File: rtl/dzpfd_retime.sv
module dzpfd_retime #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic             clear,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] level_q
);

    logic [WIDTH-1:0] hold_d, hold_q;

    // One resampling flop per lane, standing in for a falling-edge flop.
    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        always_comb begin
            if (clear)       hold_d[g] = 1'b0;
            else if (sample) hold_d[g] = level_i[g];
            else             hold_d[g] = hold_q[g];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign level_q = hold_q;

    // R3: outputs hold between fall strobes
    a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample && !clear) |=> $stable(level_q));

    // R3: on a fall strobe the pre-strobe level is captured
    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !clear) |=> (level_q == $past(level_i)));

endmodule

// File: rtl/dzpfd_lock.sv
module dzpfd_lock #(
    parameter int unsigned LOCK_COUNT = 64,
    parameter int unsigned CNT_W      = $clog2(LOCK_COUNT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic hit,
    input  logic restart,
    output logic locked
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_COUNT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lock;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d = '0;
        end else if (!st_q.lock && sample) begin
            if (hit) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == LAST) st_d.lock = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = st_q.lock;

    // R7: lock is sticky until restart
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !restart) |=> locked);

    // R8: a found error empties the counter
    a_r8_hit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && hit && !locked) |=> (st_q.cnt == '0));

    // R9: restart empties counter and lock
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!locked && st_q.cnt == '0));

endmodule

// File: rtl/dz_freq_detector.sv
module dz_freq_detector
    import dzpfd_pkg::*;
#(
    parameter int unsigned LOCK_COUNT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_rise,
    input  logic ref_fall,
    input  logic div_rise,
    input  logic restart,
    output logic up_q,
    output logic dn_q,
    output logic enable
);

    localparam int unsigned CNT_W = $clog2(LOCK_COUNT + 1);

    err_pair_t        core_err;
    logic [LANES-1:0] core_vec, out_vec;
    logic             locked, clear_all;

    assign clear_all = locked | restart;

    dzpfd_tristate core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_rise (ref_rise),
        .div_rise (div_rise),
        .clear    (clear_all),
        .err_o    (core_err)
    );

    assign core_vec = {core_err.up, core_err.dn};

    dzpfd_retime #(.WIDTH(LANES)) retime_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (ref_fall),
        .clear   (clear_all),
        .level_i (core_vec),
        .level_q (out_vec)
    );

    dzpfd_lock #(.LOCK_COUNT(LOCK_COUNT), .CNT_W(CNT_W)) lock_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (ref_fall),
        .hit     (|core_vec),
        .restart (restart),
        .locked  (locked)
    );

    assign up_q   = out_vec[1];
    assign dn_q   = out_vec[0];
    assign enable = ~locked;

    // R7: a disabled loop sends nothing to the charge pump
    a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!up_q && !dn_q));

    // R9: restart re-enables in the next cycle
    a_r9_reenable: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> enable);

endmodule

// File: tb/dz_freq_detector_tb.sv
`timescale 1ns/1ps
module dz_freq_detector_tb_top;

    localparam int LOCKN = 64;
    localparam int PER   = 16;
    localparam int FALLC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_rise = 1'b0, ref_fall = 1'b0, div_rise = 1'b0, restart = 1'b0;
    logic up_q, dn_q, enable;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    int m_up = 0, m_dn = 0, m_uq = 0, m_dq = 0, m_cnt = 0, m_lock = 0;

    always #2 clk = ~clk;

    dz_freq_detector #(.LOCK_COUNT(LOCKN)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .ref_fall(ref_fall),
        .div_rise(div_rise), .restart(restart),
        .up_q(up_q), .dn_q(dn_q), .enable(enable)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // model: evaluated at each rising edge from the values before it
    always @(posedge clk) begin
        int a, b, nu, nd;
        if (!rst_n) begin
            m_up = 0; m_dn = 0; m_uq = 0; m_dq = 0; m_cnt = 0; m_lock = 0;
        end else if (restart) begin
            m_up = 0; m_dn = 0; m_uq = 0; m_dq = 0; m_cnt = 0; m_lock = 0;
        end else if (m_lock != 0) begin
            m_up = 0; m_dn = 0; m_uq = 0; m_dq = 0;
        end else begin
            nu = ref_fall ? m_up : m_uq;
            nd = ref_fall ? m_dn : m_dq;
            if (ref_fall) begin
                if (m_up != 0 || m_dn != 0) m_cnt = 0;
                else begin
                    m_cnt++;
                    if (m_cnt == LOCKN) m_lock = 1;
                end
            end
            a = (m_up != 0 || ref_rise) ? 1 : 0;
            b = (m_dn != 0 || div_rise) ? 1 : 0;
            if (a == 1 && b == 1) begin m_up = 0; m_dn = 0; end
            else begin m_up = a; m_dn = b; end
            m_uq = nu; m_dq = nd;
        end
    end

    // cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3", "up_q vs model", int'(up_q), m_uq);
            chk("R5", "dn_q vs model", int'(dn_q), m_dq);
            chk("R7", "enable vs model", int'(enable), (m_lock != 0) ? 0 : 1);
        end
    end

    // one reference period; div_at < 0 means no divider edge
    task automatic period(input bit has_ref, input int div_at);
        for (int c = 0; c < PER; c++) begin
            ref_rise = has_ref && (c == 0);
            ref_fall = (c == FALLC);
            div_rise = (c == div_at);
            restart  = 1'b0;
            @(negedge clk);
        end
        ref_rise = 1'b0; ref_fall = 1'b0; div_rise = 1'b0;
    endtask

    task automatic clean(input int n);
        for (int i = 0; i < n; i++) period(1'b1, 2);
    endtask

    task automatic pulse_restart();
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset up_q", int'(up_q), 0);
        chk("R1", "reset dn_q", int'(dn_q), 0);
        chk("R1", "reset enable", int'(enable), 1);

        // R4: narrow up error, inside dead zone
        period(1'b1, 3);
        chk("R4", "narrow up suppressed", int'(up_q), 0);
        // R2/R4: wide up error passes
        period(1'b1, 12);
        chk("R2", "wide up passed", int'(up_q), 1);
        // R4 boundary: ends at cycle 7 -> suppressed
        period(1'b1, 7);
        chk("R4", "width 7 suppressed", int'(up_q), 0);
        // R4 boundary: ends at cycle 8 -> passed
        period(1'b1, 8);
        chk("R4", "width 8 passed", int'(up_q), 1);
        // R6: coincident strobes raise nothing
        period(1'b1, 0);
        chk("R6", "coincident up_q", int'(up_q), 0);
        chk("R6", "coincident dn_q", int'(dn_q), 0);
        // R5: divider leads -> down error
        period(1'b0, 1);
        chk("R5", "lead gives dn_q", int'(dn_q), 1);
        chk("R5", "lead no up_q", int'(up_q), 0);
        period(1'b1, -1);
        chk("R5", "ref clears dn", int'(dn_q), 0);

        // R7: exact lock count
        period(1'b1, 12);
        clean(LOCKN - 1);
        chk("R7", "one short of lock", int'(enable), 1);
        clean(1);
        chk("R7", "locked after count", int'(enable), 0);
        period(1'b1, 12);
        chk("R7", "wide error ignored when locked", int'(up_q), 0);
        chk("R7", "stays locked", int'(enable), 0);

        // R9: restart re-arms
        pulse_restart();
        chk("R9", "enable after restart", int'(enable), 1);
        chk("R9", "up_q after restart", int'(up_q), 0);

        // R8: found error empties the counter
        clean(40);
        period(1'b1, 12);
        clean(40);
        chk("R8", "counter restarted by error", int'(enable), 1);
        clean(23);
        chk("R8", "still short of lock", int'(enable), 1);
        clean(1);
        chk("R8", "lock after fresh count", int'(enable), 0);

        // R9: restart mid-count empties the counter
        pulse_restart();
        clean(40);
        pulse_restart();
        clean(40);
        chk("R9", "count cleared by restart", int'(enable), 1);
        clean(24);
        chk("R9", "lock after full count", int'(enable), 0);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule